// File: doc/BRIEF.md
# Converter-Driven Heating Thermostat Sequencer

This block runs a heating thermostat around an external 8-bit converter that sits on a simple active-low strobe bus. On a fixed cadence it pulls the chip select and write strobe low to start a conversion. It then waits for the converter's active-low completion signal and pulls chip select and the read strobe low to fetch the temperature code. Every fresh code is compared with a stored set-point, and heating and cooling outputs are switched with a hysteresis band around it, so they do not chatter when the reading sits close to the set-point.

Two debounced push buttons raise and lower the set-point, which stays inside the code range. A held button repeats the step at a fixed interval. A display path reports a value in degrees, which is the code times a configured degrees-per-code factor. It shows the set-point while a button is held and for a hold time after release, and the latest measurement at all other times. If the converter never signals completion, the block stops heating and cooling and raises a fault. The fault is cleared by the next good reading.

Top module: `thermostat_ctrl`

## Requirements
- R1: While reset is held, all three bus strobes are high (1), heat_on, cool_on, fault and disp_is_setpt are 0, and disp_deg is 0.
- R2: PERIOD clock cycles after the block goes idle, it drives cnv_cs_n and cnv_wr_n low together for exactly PULSE cycles to start a conversion.
- R3: A read starts only in the cycle after cnv_int_n is sampled low. During a read, cnv_cs_n and cnv_rd_n are low for PULSE cycles. cnv_data is captured on the last of those cycles. The write and read strobes are never low at the same time.
- R4: When no button is active, disp_deg equals the last captured code times DEG_PER_CODE, two clock edges after cnv_rd_n returns high.
- R5: With only btn_up (or only btn_dn) high, the set-point moves one code up (or down) on the first sampled edge and then once every REPEAT cycles while the button stays high. With both buttons high it does not change. Between two cycles it never changes by more than one code.
- R6: The set-point saturates at code 0 and at code 255 and never wraps.
- R7: Using the captured code t and set-point s, each reading applies these rules. If t+HYST < s, heat_on becomes 1 and cool_on becomes 0. If t > s+HYST, heat_on becomes 0 and cool_on becomes 1 (when EN_COOL=1). Otherwise both keep their values. The two are never 1 together.
- R8: If cnv_int_n stays high for TIMEOUT cycles after a write strobe, fault becomes 1 and heat_on and cool_on become 0, with no read issued. The next completed read clears fault.
- R9: disp_is_setpt is 1, and disp_deg shows the set-point times DEG_PER_CODE, from the edge after any button is sampled high until DISP_HOLD cycles after the last such edge. After that it falls back to the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_cs_n | output | 1 | Converter chip select, active low |
| cnv_wr_n | output | 1 | Conversion start strobe, active low |
| cnv_rd_n | output | 1 | Result read strobe, active low |
| cnv_int_n | input | 1 | Conversion complete from converter, active low |
| cnv_data | input | CODE_W | Result code from converter |
| btn_up | input | 1 | Raise set-point button, debounced, active high |
| btn_dn | input | 1 | Lower set-point button, debounced, active high |
| heat_on | output | 1 | Heater enable |
| cool_on | output | 1 | Cooler enable (0 when EN_COOL=0) |
| fault | output | 1 | Converter timeout seen since last good read |
| disp_is_setpt | output | 1 | Display currently shows the set-point |
| disp_deg | output | DEG_W | Displayed value in degrees |

## Verification
The timeout path is the hardest case to reach, because a correct converter always answers. The bench's bus-peripheral model therefore has a mute switch. The switch is turned on only after a cold reading has switched the heater on, so that forcing the heater off can be observed. The switch is then released, and the bench checks that the fault clears on the next reading. The hysteresis holds are reached by walking the reading onto the exact band edges, s-HYST and s+HYST, after the outputs have been set from the opposite side. Saturation is reached by holding one button for longer than the full code range takes at the repeat rate.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_START = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_READ  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/thermo_bus_seq.sv
// Drives the converter strobes: timed start, wait for completion, read.
module thermo_bus_seq
    import thermo_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int PERIOD  = 1000,
    parameter int TIMEOUT = 200,
    parameter int PULSE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_n,
    input  logic [CODE_W-1:0] data_in,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic              done,
    output logic              tmo,
    output logic [CODE_W-1:0] code
);
    localparam int CNT_MAX = (PERIOD > TIMEOUT) ? ((PERIOD > PULSE) ? PERIOD : PULSE)
                                                : ((TIMEOUT > PULSE) ? TIMEOUT : PULSE);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic              done;
        logic              tmo;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.tmo  = 1'b0;
        d.cnt  = q.cnt + 1'b1;
        case (q.st)
            SQ_IDLE: if (q.cnt == CNT_W'(PERIOD - 1)) begin
                d.st  = SQ_START;
                d.cnt = '0;
            end
            SQ_START: if (q.cnt == CNT_W'(PULSE - 1)) begin
                d.st  = SQ_WAIT;
                d.cnt = '0;
            end
            SQ_WAIT: if (!int_n) begin
                d.st  = SQ_READ;
                d.cnt = '0;
            end else if (q.cnt == CNT_W'(TIMEOUT - 1)) begin
                d.st  = SQ_IDLE;
                d.cnt = '0;
                d.tmo = 1'b1;
            end
            SQ_READ: if (q.cnt == CNT_W'(PULSE - 1)) begin
                d.st   = SQ_IDLE;
                d.cnt  = '0;
                d.code = data_in;
                d.done = 1'b1;
            end
            default: begin
                d.st  = SQ_IDLE;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{SQ_IDLE, '0, '0, 1'b0, 1'b0};
        else        q <= d;
    end

    assign cs_n = !((q.st == SQ_START) || (q.st == SQ_READ));
    assign wr_n = (q.st != SQ_START);
    assign rd_n = (q.st != SQ_READ);
    assign done = q.done;
    assign tmo  = q.tmo;
    assign code = q.code;
endmodule

// File: rtl/thermo_setpt.sv
// Button-driven set-point with auto-repeat and the display hold timer.
module thermo_setpt #(
    parameter int CODE_W     = 8,
    parameter int REPEAT     = 100,
    parameter int DISP_HOLD  = 1000,
    parameter int SETPT_INIT = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_up,
    input  logic              btn_dn,
    output logic [CODE_W-1:0] setpt,
    output logic              show
);
    localparam int REP_W  = $clog2(REPEAT + 1);
    localparam int HOLD_W = $clog2(DISP_HOLD + 1);
    localparam logic [CODE_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CODE_W-1:0] setpt;
        logic [REP_W-1:0]  rep;
        logic [HOLD_W-1:0] hold;
    } sp_t;

    sp_t q, d;
    logic any_btn;

    always_comb begin
        d       = q;
        any_btn = btn_up | btn_dn;
        if (!any_btn) begin
            d.rep = '0;
        end else if (q.rep == '0) begin
            d.rep = REP_W'(REPEAT - 1);
            if (btn_up && !btn_dn && q.setpt != TOP) d.setpt = q.setpt + 1'b1;
            if (btn_dn && !btn_up && q.setpt != '0)  d.setpt = q.setpt - 1'b1;
        end else begin
            d.rep = q.rep - 1'b1;
        end
        if (any_btn)          d.hold = HOLD_W'(DISP_HOLD);
        else if (q.hold != 0) d.hold = q.hold - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{CODE_W'(SETPT_INIT), '0, '0};
        else        q <= d;
    end

    assign setpt = q.setpt;
    assign show  = (q.hold != '0);
endmodule

// File: rtl/thermo_ctrl.sv
// Hysteresis decision and fault handling, updated per reading or timeout.
module thermo_ctrl #(
    parameter int CODE_W = 8,
    parameter int HYST   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              tmo,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] setpt,
    output logic              heat,
    output logic              cool,
    output logic              fault,
    output logic [CODE_W-1:0] temp
);
    localparam int CMP_W = CODE_W + 2;

    typedef struct packed {
        logic              heat;
        logic              cool;
        logic              fault;
        logic [CODE_W-1:0] temp;
    } ctl_t;

    ctl_t q, d;
    logic [CMP_W-1:0] t_lo, s_hi;

    always_comb begin
        d    = q;
        t_lo = CMP_W'(code) + CMP_W'(HYST);
        s_hi = CMP_W'(setpt) + CMP_W'(HYST);
        if (done) begin
            d.temp  = code;
            d.fault = 1'b0;
            if (t_lo < CMP_W'(setpt)) begin
                d.heat = 1'b1;
                d.cool = 1'b0;
            end else if (CMP_W'(code) > s_hi) begin
                d.heat = 1'b0;
                d.cool = 1'b1;
            end
        end else if (tmo) begin
            d.fault = 1'b1;
            d.heat  = 1'b0;
            d.cool  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign heat  = q.heat;
    assign cool  = q.cool;
    assign fault = q.fault;
    assign temp  = q.temp;
endmodule

// File: rtl/thermostat_ctrl.sv
module thermostat_ctrl #(
    parameter int CODE_W       = 8,
    parameter int PERIOD       = 1000,
    parameter int TIMEOUT      = 200,
    parameter int PULSE        = 2,
    parameter int HYST         = 1,
    parameter int DEG_PER_CODE = 2,
    parameter int REPEAT       = 100,
    parameter int DISP_HOLD    = 1000,
    parameter int SETPT_INIT   = 100,
    parameter bit EN_COOL      = 1'b1,
    localparam int DEG_W       = CODE_W + $clog2(DEG_PER_CODE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cnv_cs_n,
    output logic              cnv_wr_n,
    output logic              cnv_rd_n,
    input  logic              cnv_int_n,
    input  logic [CODE_W-1:0] cnv_data,
    input  logic              btn_up,
    input  logic              btn_dn,
    output logic              heat_on,
    output logic              cool_on,
    output logic              fault,
    output logic              disp_is_setpt,
    output logic [DEG_W-1:0]  disp_deg
);
    logic              rd_done, rd_tmo, cool_raw, show;
    logic [CODE_W-1:0] rd_code, setpt_code, temp_code, shown;

    thermo_bus_seq #(.CODE_W(CODE_W), .PERIOD(PERIOD), .TIMEOUT(TIMEOUT), .PULSE(PULSE)) u_seq (
        .clk(clk), .rst_n(rst_n), .int_n(cnv_int_n), .data_in(cnv_data),
        .cs_n(cnv_cs_n), .wr_n(cnv_wr_n), .rd_n(cnv_rd_n),
        .done(rd_done), .tmo(rd_tmo), .code(rd_code)
    );

    thermo_setpt #(.CODE_W(CODE_W), .REPEAT(REPEAT), .DISP_HOLD(DISP_HOLD),
                   .SETPT_INIT(SETPT_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n), .btn_up(btn_up), .btn_dn(btn_dn),
        .setpt(setpt_code), .show(show)
    );

    thermo_ctrl #(.CODE_W(CODE_W), .HYST(HYST)) u_ctl (
        .clk(clk), .rst_n(rst_n), .done(rd_done), .tmo(rd_tmo), .code(rd_code),
        .setpt(setpt_code), .heat(heat_on), .cool(cool_raw), .fault(fault), .temp(temp_code)
    );

    generate
        if (EN_COOL) begin : g_cool
            assign cool_on = cool_raw;
        end else begin : g_nocool
            assign cool_on = 1'b0;
        end
    endgenerate

    assign disp_is_setpt = show;
    assign shown         = show ? setpt_code : temp_code;

    generate
        if ((DEG_PER_CODE & (DEG_PER_CODE - 1)) == 0) begin : g_shift
            assign disp_deg = DEG_W'(shown) << $clog2(DEG_PER_CODE);
        end else begin : g_mult
            assign disp_deg = DEG_W'(shown) * DEG_W'(DEG_PER_CODE);
        end
    endgenerate
endmodule

// File: rtl/thermostat_ctrl_chk.sv
module thermostat_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              rd_n,
    input logic              int_n,
    input logic              heat,
    input logic              cool,
    input logic              fault,
    input logic [CODE_W-1:0] setpt
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n)); // R3
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n) |-> !cs_n); // R2
    AST_READ_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(!int_n)); // R3
    AST_HEAT_COOL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(heat && cool)); // R7
    AST_FAULT_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!heat && !cool)); // R8
    AST_SETPT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (setpt != $past(setpt)) |->
        (({1'b0, setpt} == {1'b0, $past(setpt)} + 1'b1) ||
         ({1'b0, $past(setpt)} == {1'b0, setpt} + 1'b1))); // R5
endmodule

bind thermostat_ctrl thermostat_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cnv_cs_n), .wr_n(cnv_wr_n), .rd_n(cnv_rd_n),
    .int_n(cnv_int_n), .heat(heat_on), .cool(cool_on), .fault(fault), .setpt(setpt_code)
);

// File: tb/thermostat_ctrl_bench.sv
`timescale 1ns/1ps
module thermostat_ctrl_bench;
    localparam int PERIOD = 20, TIMEOUT = 40, PULSE = 2, HYST = 2, DEG = 2;
    localparam int REPEAT = 5, DISP_HOLD = 10, SP0 = 100, CONV_LAT = 8;
    localparam int DEG_W = 8 + $clog2(DEG + 1);

    logic clk = 0, rst_n = 0;
    logic cs_n, wr_n, rd_n, int_n = 1;
    logic [7:0] adc_val = 0;
    logic up = 0, dn = 0, heat, cool, fault, show;
    logic [DEG_W-1:0] deg;
    bit mute = 0, sb_on = 1, fin = 0;
    int n_chk = 0, n_bad = 0, pops = 0, rd_cnt = 0, bad_rd = 0, cyc = 0;

    always #4 clk = ~clk;

    thermostat_ctrl #(.PERIOD(PERIOD), .TIMEOUT(TIMEOUT), .PULSE(PULSE), .HYST(HYST),
        .DEG_PER_CODE(DEG), .REPEAT(REPEAT), .DISP_HOLD(DISP_HOLD), .SETPT_INIT(SP0))
    u_thermostat_ctrl (
        .clk(clk), .rst_n(rst_n), .cnv_cs_n(cs_n), .cnv_wr_n(wr_n), .cnv_rd_n(rd_n),
        .cnv_int_n(int_n), .cnv_data(adc_val), .btn_up(up), .btn_dn(dn),
        .heat_on(heat), .cool_on(cool), .fault(fault), .disp_is_setpt(show), .disp_deg(deg)
    );

    typedef struct { int deg; bit h; bit c; bit f; } item_t;
    item_t exq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // converter modelled as a bus peripheral, acting on the falling clock edge
    logic prev_wr = 1, prev_rd = 1;
    bit busy = 0;
    int lat = 0;
    always @(negedge clk) begin
        prev_wr <= wr_n;
        prev_rd <= rd_n;
        if (!rst_n) begin
            int_n <= 1; busy <= 0;
        end else begin
            if (prev_rd && !rd_n) begin
                rd_cnt <= rd_cnt + 1;
                if (int_n) bad_rd <= bad_rd + 1;
            end
            if (!cs_n && !wr_n) begin
                int_n <= 1; busy <= 0;
            end else if (!prev_wr && wr_n) begin
                busy <= 1; lat <= CONV_LAT;
            end else if (busy) begin
                if (lat == 0) begin busy <= 0; if (!mute) int_n <= 0; end
                else lat <= lat - 1;
            end
            if (!cs_n && !rd_n) int_n <= 1;
        end
    end

    // scoreboard monitor: results settle two edges after the read strobe ends
    always begin
        @(posedge rd_n);
        if (rst_n && sb_on && exq.size() > 0) begin
            item_t e;
            repeat (2) @(posedge clk);
            #2;
            e = exq.pop_front();
            check(deg == e.deg[DEG_W-1:0] && !show, "R4 displayed temperature", deg, e.deg);
            check(heat == e.h, "R7 heat_on", heat, e.h);
            check(cool == e.c, "R7 cool_on", cool, e.c);
            check(fault == e.f, "R8 fault after good read", fault, e.f);
            pops++;
        end
    end

    bit mh = 0, mc = 0;
    task automatic convert(input int v, input int sp);
        item_t e;
        if (v + HYST < sp) begin mh = 1; mc = 0; end
        else if (v > sp + HYST) begin mh = 0; mc = 1; end
        e.deg = v * DEG; e.h = mh; e.c = mc; e.f = 0;
        adc_val = 8'(v);
        exq.push_back(e);
        wait (pops > 0 && exq.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic press(input bit u, input bit d, input int n);
        @(posedge clk); #1;
        up = u; dn = d;
        repeat (n) @(posedge clk);
        #1; up = 0; dn = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w, base;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check(cs_n && wr_n && rd_n, "R1 strobes idle", {cs_n, wr_n, rd_n}, 7);
        check(!heat && !cool && !fault, "R1 outputs off", {heat, cool, fault}, 0);
        check(!show && deg == 0, "R1 display", deg, 0);
        @(posedge clk); #1 rst_n = 1;

        // R2 start strobe width
        adc_val = 8'd90;
        @(negedge wr_n);
        check(cs_n == 0, "R2 chip select with write", cs_n, 0);
        w = 0;
        while (!wr_n) begin @(posedge clk); #1; w++; end
        check(w == PULSE, "R2 write strobe width", w, PULSE);

        // R7 hysteresis walk with set-point SP0=100, band 2
        convert(90, SP0);
        convert(99, SP0);
        convert(103, SP0);
        convert(101, SP0);
        convert(97, SP0);
        convert(102, SP0);   // upper band edge: hold heat
        convert(255, SP0);
        convert(98, SP0);    // lower band edge: hold cool
        convert(0, SP0);
        sb_on = 0;
        check(bad_rd == 0, "R3 read only after completion", bad_rd, 0);

        // R8 timeout with heater on
        check(heat == 1, "R8 heater on before timeout", heat, 1);
        mute = 1;
        base = rd_cnt;
        w = 0;
        while (!fault && w < 500) begin @(posedge clk); #1; w++; end
        check(fault == 1, "R8 fault raised", fault, 1);
        check(!heat && !cool, "R8 outputs forced off", {heat, cool}, 0);
        check(rd_cnt == base, "R8 no read on timeout", rd_cnt - base, 0);
        mute = 0;
        w = 0;
        while (fault && w < 500) begin @(posedge clk); #1; w++; end
        check(fault == 0, "R8 fault cleared by good read", fault, 0);
        @(posedge clk); #1;
        check(heat == 1, "R8 heat resumes", heat, 1);

        // R5 and R9 auto-repeat: 12 sampled edges give three steps
        press(1, 0, 12);
        check(show == 1, "R9 set-point shown after release", show, 1);
        check(deg == (SP0 + 3) * DEG, "R5 repeat stepping", deg, (SP0 + 3) * DEG);
        repeat (5) @(posedge clk); #1;
        check(show == 1, "R9 hold still active", show, 1);
        repeat (7) @(posedge clk); #1;
        check(show == 0 && deg == 0, "R9 fallback to temperature", deg, 0);

        press(1, 1, 10);
        check(deg == (SP0 + 3) * DEG, "R5 both buttons no change", deg, (SP0 + 3) * DEG);

        // R6 saturation at both ends
        @(posedge clk); #1; up = 1;
        repeat (900) @(posedge clk); #1;
        check(deg == 255 * DEG, "R6 saturate high", deg, 255 * DEG);
        up = 0; dn = 1;
        repeat (1400) @(posedge clk); #1;
        check(deg == 0 && show, "R6 saturate low", deg, 0);
        dn = 0;
        press(0, 1, 3);
        check(deg == 0, "R6 no wrap below zero", deg, 0);

        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule